// File: doc/BRIEF.md
# Instrument Status and Service-Request Logic

This block keeps the event-status side of a remote-controlled instrument's status reporting. It has an eight-bit event register. Its bits are set by single-cycle event pulses and stay set until the register is read or a clear-status strobe arrives. Nothing can write the register directly. Bit 0 records that an operation-complete request has been honoured. That happens only once the instrument reports that no operation is still in progress. Bit 1 is tied to zero.

It also has an eight-bit service-request enable mask. The mask is ANDed with the summary bits of an external status byte. When a masked summary bit becomes true, the block raises a registered, one-cycle service request. A condition that stays true raises no further requests. It re-arms only when its status bit or its enable bit has gone to zero and then returns. Enable bit 6 is tied to zero.

Top module: `instr_status_srq`

## Requirements
- R1: After reset, `srq` is 0 and `en_rdata` is 0x00. The event register holds only bit 7 (power-on), so the first read returns 0x80.
- R2: A one-cycle pulse on `ev_in[k]` for k in 2..7 sets event bit k. The bits are: 2 query error, 3 device-dependent error, 4 execution error, 5 command error, 6 user request, 7 power-on. The bit stays set until the register is cleared.
- R3: Event bit 1 always reads 0. Pulses on `ev_in[1]` and `ev_in[0]` have no effect on the register.
- R4: An `op_req` pulse sets event bit 0 on the next edge if `ops_busy` is low. If `ops_busy` is high, the request is held, and bit 0 is set on the first edge at which `ops_busy` is low.
- R5: An `evt_rd` strobe loads the register value into `evt_rdata` at that edge and clears the register. `evt_rdata` then holds that value until the next read.
- R6: A `clr_stat` strobe clears the event register and leaves `evt_rdata` unchanged.
- R7: An event pulse in the same cycle as a read or a clear is kept in the register after that edge. A read in that cycle returns the value from before the edge.
- R8: An `en_wr` strobe loads `en_wdata` into the enable mask, which is visible on `en_rdata` from the next cycle. Bit 6 always reads 0. Writing 0x00 clears the mask.
- R9: When some bit of `stb_in & mask` goes from 0 to 1, `srq` is 1 for exactly one cycle, starting one cycle later. A status bit whose enable bit is 0, including bit 6, never causes a request.
- R10: While a qualifying condition stays true, no further request is raised. Clearing either its status bit or its enable bit re-arms it, and it fires again when the condition returns.
- R11: A new qualifying bit rising while another is already held raises a new request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_in | input | 8 | Event pulses, one bit per event register bit |
| op_req | input | 1 | Operation-complete request pulse |
| ops_busy | input | 1 | High while any operation is pending |
| evt_rd | input | 1 | Read-and-clear strobe for the event register |
| clr_stat | input | 1 | Clear-status strobe |
| evt_rdata | output | 8 | Last value read from the event register |
| en_wr | input | 1 | Enable mask write strobe |
| en_wdata | input | 8 | Enable mask write data |
| en_rdata | output | 8 | Current enable mask |
| stb_in | input | 8 | Summary bits of the status byte |
| srq | output | 1 | One-cycle service request |

## Verification
The event register's clearing paths and its setting paths can act at the same edge. The bench provokes this by pulsing an event bit in the same cycle as a read strobe, and again in the same cycle as a clear strobe. It judges the result by checking that the read returns only the older bits and that the next read returns the new bit alone. The service-request detector also has a race: an enable write and a held status bit can change the qualifying set at the same edge. The bench drops and restores enable bits under a held status byte and checks `srq` cycle by cycle against the expected pulse position.

// File: rtl/stat_pkg.sv
package stat_pkg;
  localparam int STAT_W = 8;
  localparam int BIT_OPDONE = 0;
  localparam int BIT_REQCTL = 1;
  localparam int BIT_PWRON = 7;
  localparam int BIT_EN_TIED = 6;
  localparam logic [STAT_W-1:0] OPDONE_MASK = STAT_W'(1) << BIT_OPDONE;
  localparam logic [STAT_W-1:0] EVT_ZERO_MASK = STAT_W'(1) << BIT_REQCTL;
  localparam logic [STAT_W-1:0] EVT_RST_VAL = STAT_W'(1) << BIT_PWRON;
  localparam logic [STAT_W-1:0] EN_ZERO_MASK = STAT_W'(1) << BIT_EN_TIED;
endpackage

// File: rtl/stat_opdone.sv
module stat_opdone (
  input  logic clk,
  input  logic rst,
  input  logic op_req,
  input  logic ops_busy,
  output logic done
);
  logic pend_q;
  logic want;

  assign want = pend_q | op_req;
  assign done = want & ~ops_busy;

  always_ff @(posedge clk) begin
    if (rst) pend_q <= 1'b0;
    else     pend_q <= want & ops_busy;
  end

  // R4: a held request drains as soon as the busy flag drops
  assert_pend_drains_R4: assert property (@(posedge clk) disable iff (rst)
    (pend_q && !ops_busy) |=> !pend_q);
endmodule

// File: rtl/stat_evt_reg.sv
module stat_evt_reg #(
  parameter int W = 8,
  parameter logic [W-1:0] ZERO_MASK = '0,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set_in,
  input  logic         rd,
  input  logic         clr,
  output logic [W-1:0] rdata
);
  localparam logic [W-1:0] RST_EFF = RST_VAL & ~ZERO_MASK;

  logic [W-1:0] q;
  logic [W-1:0] set_eff;
  logic         wipe;

  assign set_eff = set_in & ~ZERO_MASK;
  assign wipe = rd | clr;

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)             q[i] <= RST_EFF[i];
      else if (set_eff[i]) q[i] <= 1'b1;
      else if (wipe)       q[i] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (rd) rdata <= q;
  end

  assert_sticky_R2: assert property (@(posedge clk) disable iff (rst)
    !wipe |=> ((q & $past(q)) == $past(q)));
  assert_wipe_R5: assert property (@(posedge clk) disable iff (rst)
    (wipe && set_eff == '0) |=> (q == '0));
  assert_new_wins_R7: assert property (@(posedge clk) disable iff (rst)
    (set_eff != '0) |=> ((q & $past(set_eff)) == $past(set_eff)));
  assert_rdata_R5: assert property (@(posedge clk) disable iff (rst)
    rd |=> (rdata == $past(q)));
  assert_clr_keeps_R6: assert property (@(posedge clk) disable iff (rst)
    (clr && !rd) |=> $stable(rdata));
endmodule

// File: rtl/stat_srq.sv
module stat_srq #(
  parameter int W = 8,
  parameter logic [W-1:0] EN_ZERO = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en_wr,
  input  logic [W-1:0] en_wdata,
  input  logic [W-1:0] stb_in,
  output logic [W-1:0] en_q,
  output logic         srq
);
  logic [W-1:0] qual;
  logic [W-1:0] qual_q;
  logic [W-1:0] rise;

  assign qual = stb_in & en_q;

  always_ff @(posedge clk) begin
    if (rst)        en_q <= '0;
    else if (en_wr) en_q <= en_wdata & ~EN_ZERO;
  end

  for (genvar i = 0; i < W; i++) begin : g_edge
    always_ff @(posedge clk) begin
      if (rst) qual_q[i] <= 1'b0;
      else     qual_q[i] <= qual[i];
    end
    assign rise[i] = qual[i] & ~qual_q[i];
  end

  always_ff @(posedge clk) begin
    if (rst) srq <= 1'b0;
    else     srq <= |rise;
  end

  assert_en_write_R8: assert property (@(posedge clk) disable iff (rst)
    en_wr |=> (en_q == ($past(en_wdata) & ~EN_ZERO)));
  assert_srq_cause_R9: assert property (@(posedge clk) disable iff (rst)
    srq |-> $past(|(stb_in & en_q)));
  assert_srq_once_R10: assert property (@(posedge clk) disable iff (rst)
    ($stable(stb_in) && $stable(en_q)) |=> !srq);
endmodule

// File: rtl/instr_status_srq.sv
module instr_status_srq
  import stat_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [STAT_W-1:0] ev_in,
  input  logic              op_req,
  input  logic              ops_busy,
  input  logic              evt_rd,
  input  logic              clr_stat,
  output logic [STAT_W-1:0] evt_rdata,
  input  logic              en_wr,
  input  logic [STAT_W-1:0] en_wdata,
  output logic [STAT_W-1:0] en_rdata,
  input  logic [STAT_W-1:0] stb_in,
  output logic              srq
);
  logic              op_done;
  logic [STAT_W-1:0] set_vec;

  stat_opdone u_opdone (
    .clk(clk), .rst(rst), .op_req(op_req), .ops_busy(ops_busy), .done(op_done)
  );

  assign set_vec = (ev_in & ~OPDONE_MASK) | (op_done ? OPDONE_MASK : '0);

  stat_evt_reg #(.W(STAT_W), .ZERO_MASK(EVT_ZERO_MASK), .RST_VAL(EVT_RST_VAL)) u_evt (
    .clk(clk), .rst(rst), .set_in(set_vec), .rd(evt_rd), .clr(clr_stat), .rdata(evt_rdata)
  );

  stat_srq #(.W(STAT_W), .EN_ZERO(EN_ZERO_MASK)) u_srq (
    .clk(clk), .rst(rst), .en_wr(en_wr), .en_wdata(en_wdata), .stb_in(stb_in),
    .en_q(en_rdata), .srq(srq)
  );

  assert_tied_bits_R3: assert property (@(posedge clk) disable iff (rst)
    (evt_rdata[BIT_REQCTL] == 1'b0) && (en_rdata[BIT_EN_TIED] == 1'b0));
endmodule

// File: tb/sim_instr_status_srq.sv
module sim_instr_status_srq;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [7:0] ev_in = '0;
  logic op_req = 1'b0, ops_busy = 1'b0, evt_rd = 1'b0, clr_stat = 1'b0;
  logic en_wr = 1'b0;
  logic [7:0] en_wdata = '0, stb_in = '0;
  logic [7:0] evt_rdata, en_rdata;
  logic srq;
  int checks = 0, errors = 0;
  logic [7:0] rv;

  always #4 clk = ~clk;

  instr_status_srq u0 (
    .clk(clk), .rst(rst), .ev_in(ev_in), .op_req(op_req), .ops_busy(ops_busy),
    .evt_rd(evt_rd), .clr_stat(clr_stat), .evt_rdata(evt_rdata), .en_wr(en_wr),
    .en_wdata(en_wdata), .en_rdata(en_rdata), .stb_in(stb_in), .srq(srq)
  );

  task automatic tick(); @(negedge clk); endtask

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_read(output logic [7:0] v);
    evt_rd = 1'b1; tick(); evt_rd = 1'b0; v = evt_rdata;
  endtask

  task automatic wr_en(input logic [7:0] v);
    en_wdata = v; en_wr = 1'b1; tick(); en_wr = 1'b0;
  endtask

  initial begin
    #(8 * 150000);
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    tick(); tick(); rst = 1'b0; tick();
    // R1 reset state
    check("R1 srq", {7'd0, srq}, 8'h00);
    check("R1 en", en_rdata, 8'h00);
    do_read(rv); check("R1 power-on read", rv, 8'h80);
    do_read(rv); check("R5 cleared by read", rv, 8'h00);

    // R2 / R3 per-bit sweep
    for (int k = 0; k < 8; k++) begin
      ev_in = 8'(1) << k; tick(); ev_in = '0; tick(); tick();
      do_read(rv);
      check((k >= 2) ? "R2 event bit" : "R3 ignored bit", rv, (k >= 2) ? (8'(1) << k) : 8'h00);
      do_read(rv); check("R5 clear after read", rv, 8'h00);
    end
    ev_in = 8'hFF; tick(); ev_in = '0;
    do_read(rv); check("R3 bit1 zero", rv, 8'hFC);

    // R6 clear strobe keeps rdata
    ev_in = 8'h24; tick(); ev_in = '0;
    clr_stat = 1'b1; tick(); clr_stat = 1'b0;
    check("R6 rdata unchanged", evt_rdata, 8'hFC);
    do_read(rv); check("R6 cleared", rv, 8'h00);

    // R7 same-cycle read/clear and event
    ev_in = 8'h10; tick(); ev_in = 8'h20; evt_rd = 1'b1; tick(); ev_in = '0; evt_rd = 1'b0;
    check("R7 read old value", evt_rdata, 8'h10);
    do_read(rv); check("R7 new event kept", rv, 8'h20);
    ev_in = 8'h08; clr_stat = 1'b1; tick(); ev_in = '0; clr_stat = 1'b0;
    do_read(rv); check("R7 event beats clear", rv, 8'h08);

    // R4 operation complete
    op_req = 1'b1; tick(); op_req = 1'b0;
    do_read(rv); check("R4 immediate", rv, 8'h01);
    ops_busy = 1'b1; op_req = 1'b1; tick(); op_req = 1'b0; tick(); tick();
    do_read(rv); check("R4 held while busy", rv, 8'h00);
    ops_busy = 1'b0; tick(); tick();
    do_read(rv); check("R4 after busy drops", rv, 8'h01);

    // R8 full enable sweep
    for (int v = 0; v < 256; v++) begin
      wr_en(8'(v)); check("R8 enable readback", en_rdata, 8'(v) & 8'hBF);
      check("R9 no srq with stb zero", {7'd0, srq}, 8'h00);
    end
    wr_en(8'h00); check("R8 write zero clears", en_rdata, 8'h00);

    // R9 disabled condition never requests, then enabling fires
    stb_in = 8'h01; tick(); tick();
    check("R9 masked no srq", {7'd0, srq}, 8'h00);
    wr_en(8'hFF); check("R9 not yet", {7'd0, srq}, 8'h00);
    tick(); check("R9 fire on enable", {7'd0, srq}, 8'h01);
    tick(); check("R9 one cycle", {7'd0, srq}, 8'h00);
    // R11 another bit rising while bit 0 held
    stb_in = 8'h05; tick(); check("R11 second condition", {7'd0, srq}, 8'h01);
    tick(); check("R11 one cycle", {7'd0, srq}, 8'h00);
    stb_in = 8'h00; tick(); tick();

    // R9 / R10 per-bit re-arm sweep
    for (int b = 0; b < 8; b++) begin
      logic [7:0] m = 8'(1) << b;
      logic [7:0] e = (b == 6) ? 8'h00 : 8'h01;
      stb_in = m; tick(); check("R9 rise", {7'd0, srq}, e);
      tick(); tick(); tick(); check("R10 held no repeat", {7'd0, srq}, 8'h00);
      stb_in = 8'h00; tick(); check("R10 drop no srq", {7'd0, srq}, 8'h00);
      stb_in = m; tick(); check("R10 re-arm via status", {7'd0, srq}, e);
      tick();
      wr_en(8'hFF & ~m); check("R10 enable drop", {7'd0, srq}, 8'h00);
      tick();
      wr_en(8'hFF); check("R10 enable restore lag", {7'd0, srq}, 8'h00);
      tick(); check("R10 re-arm via enable", {7'd0, srq}, e);
      stb_in = 8'h00; tick(); tick();
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule